// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits on the slave side of a two-wire serial bus. It samples the clock line (SCL) and the data line (SDA), cleans both, and finds start, repeated-start and stop conditions. It then collects the first frame after each start as an address and compares it with an own address supplied on an input. That address may be 7 bits or 10 bits wide. On a hit, the block pulls SDA low through the acknowledge slot.

A downstream data engine reads three things from it. `selected` shows that this slave is addressed. `slave_tx` shows that the master asked for a read. `frame_strobe` marks the end of every 9-clock frame that runs while the slave is selected.

In 10-bit mode, a write is accepted after two address frames: the short upper frame and then the low byte. After such a write, a repeated start followed by the upper frame with the read bit set selects the slave for reading. The low byte is not sent again. The selection is not dropped by the repeated start itself; only a stop or a non-matching address frame drops it.

Top module: `i2c_addr_match`

## Requirements
- R1: A fall of SDA while SCL is high starts a new address frame. A rise of SDA while SCL is high is a stop, and it clears `selected`, `slave_tx` and all 10-bit progress.
- R2: In 7-bit mode (`ten_bit_mode`=0), frame bits are taken MSB first on SCL rises. When the first seven bits equal `own_addr[6:0]`, `sda_oe` holds SDA low during the ninth clock and `selected` goes to 1.
- R3: The eighth bit of a matched address frame is the direction. 1 sets `slave_tx` (the slave transmits) and 0 clears it.
- R4: A non-matching address frame is not acknowledged, and it clears `selected` even if the slave was selected before.
- R5: `selected` keeps its value across a repeated start and through data frames, until the next address frame is evaluated or a stop occurs.
- R6: In 10-bit mode, the frame `11110`,`own_addr[9:8]`,0 is acknowledged but does not select the slave. The following frame equal to `own_addr[7:0]` is acknowledged and selects the slave with `slave_tx`=0. An upper frame with other address bits is not acknowledged.
- R7: In 10-bit mode, after a completed write match, a repeated start plus the frame `11110`,`own_addr[9:8]`,1 is acknowledged and selects the slave with `slave_tx`=1.
- R8: A stop, or a non-matching address frame, discards a pending 10-bit match. A later upper frame with the read bit is then not acknowledged and leaves `selected`=0.
- R9: `frame_strobe` is a one-cycle pulse after the ninth SCL fall of each frame during which the slave is selected, the address frame included.
- R10: An SCL or SDA pulse shorter than `FILT_LEN` clock cycles has no effect.
- R11: After reset, `sda_oe`, `selected`, `slave_tx` and `frame_strobe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| own_addr | input | 10 | Own address; bits 6:0 are used in 7-bit mode |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| selected | output | 1 | Slave is currently addressed |
| slave_tx | output | 1 | Addressed for a read (slave transmits) |
| frame_strobe | output | 1 | One-cycle pulse at each frame end while selected |

## Verification
The bench builds the block with `FILT_LEN`=3. This makes a 2-cycle pulse on SDA, one cycle short of acceptance, a meaningful test of the filter. The bus half-period is 16 system clocks, so every acknowledge can be sampled well after the synchronizer and filter delay. Both addressing modes are reached through the `ten_bit_mode` input in one run. This covers the two-frame write, the read after a repeated start, and the loss of pending 10-bit state after a stop or a wrong low byte.

// File: rtl/i2c_addr_match.sv
`timescale 1ns/1ps
module i2c_addr_match #(
  parameter int FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [9:0] own_addr,
  input  logic       ten_bit_mode,
  output logic       sda_oe,
  output logic       selected,
  output logic       slave_tx,
  output logic       frame_strobe
);
  localparam int FW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [1:0] P_IDLE = 2'd0, P_ADR = 2'd1, P_LOW = 2'd2, P_DAT = 2'd3;

  // bit 1 = SCL, bit 0 = SDA
  logic [1:0] s1, s2, flt, prv;
  logic [FW-1:0] fcnt [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 2'b11; s2 <= 2'b11; flt <= 2'b11; prv <= 2'b11;
      fcnt[0] <= '0; fcnt[1] <= '0;
    end else begin
      s1  <= {scl_i, sda_i};
      s2  <= s1;
      prv <= flt;
      for (int i = 0; i < 2; i++) begin
        if (s2[i] == flt[i]) fcnt[i] <= '0;
        else if (fcnt[i] == FW'(FILT_LEN - 1)) begin
          flt[i]  <= s2[i];
          fcnt[i] <= '0;
        end else fcnt[i] <= fcnt[i] + 1'b1;
      end
    end
  end

  wire start_det = flt[1] & prv[1] &  prv[0] & ~flt[0];
  wire stop_det  = flt[1] & prv[1] & ~prv[0] &  flt[0];
  wire scl_rise  =  flt[1] & ~prv[1];
  wire scl_fall  = ~flt[1] &  prv[1];

  logic [1:0] phase;
  logic [3:0] bcnt;
  logic [7:0] shr;
  logic       hi_ok, ten_ok;

  wire hi_hit    = shr[7:1] == {5'b11110, own_addr[9:8]};
  wire seven_hit = shr[7:1] == own_addr[6:0];

  logic ack_n, sel_n, dir_n, hi_n, ten_n;
  always_comb begin
    {ack_n, sel_n, dir_n, hi_n, ten_n} = '0;
    if (phase == P_LOW) begin
      if (hi_ok && shr == own_addr[7:0]) {ack_n, sel_n, ten_n} = 3'b111;
    end else if (!ten_bit_mode) begin
      if (seven_hit) {ack_n, sel_n, dir_n} = {2'b11, shr[0]};
    end else if (hi_hit) begin
      if (!shr[0]) {ack_n, hi_n} = 2'b11;
      else if (ten_ok) {ack_n, sel_n, dir_n, ten_n} = 4'b1111;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_IDLE; bcnt <= '0; shr <= '0;
      hi_ok <= 1'b0; ten_ok <= 1'b0;
      sda_oe <= 1'b0; selected <= 1'b0; slave_tx <= 1'b0; frame_strobe <= 1'b0;
    end else begin
      frame_strobe <= 1'b0;
      if (start_det) begin
        phase  <= P_ADR;
        bcnt   <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        phase <= P_IDLE; bcnt <= '0;
        hi_ok <= 1'b0; ten_ok <= 1'b0;
        sda_oe <= 1'b0; selected <= 1'b0; slave_tx <= 1'b0;
      end else begin
        if (scl_rise && phase != P_IDLE && bcnt != 4'd9) begin
          bcnt <= bcnt + 4'd1;
          shr  <= {shr[6:0], flt[0]};
        end
        if (scl_fall && bcnt == 4'd8 && (phase == P_ADR || phase == P_LOW)) begin
          sda_oe   <= ack_n;
          selected <= sel_n;
          slave_tx <= dir_n;
          hi_ok    <= hi_n;
          ten_ok   <= ten_n;
        end
        if (scl_fall && bcnt == 4'd9) begin
          sda_oe       <= 1'b0;
          bcnt         <= '0;
          frame_strobe <= selected;
          phase        <= hi_ok ? P_LOW : (selected ? P_DAT : P_IDLE);
        end
      end
    end
  end

  AST_ACK_IN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (bcnt == 4'd8 || bcnt == 4'd9)); // R2
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!selected && !sda_oe && !ten_ok && !hi_ok)); // R1
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |=> !frame_strobe); // R9
  AST_STROBE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    frame_strobe |-> selected); // R9
  AST_SEL_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_DAT && !stop_det) |=> $stable(selected)); // R5
endmodule

// File: tb/i2c_addr_match_test.sv
`timescale 1ns/1ps
module i2c_addr_match_test;
  localparam int H = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic [9:0] own_addr = '0;
  logic ten_bit_mode = 1'b0;
  logic sda_oe, selected, slave_tx, frame_strobe;
  wire  sda_bus = sda_m & ~sda_oe;
  int nchk = 0, nerr = 0, nstb = 0;
  logic ack;

  always #4 clk = ~clk;

  i2c_addr_match #(.FILT_LEN(3)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .own_addr(own_addr), .ten_bit_mode(ten_bit_mode),
    .sda_oe(sda_oe), .selected(selected), .slave_tx(slave_tx), .frame_strobe(frame_strobe));

  always @(negedge clk) if (frame_strobe) nstb++;

  // {own7, frame byte, expected ack, expected direction}
  localparam logic [16:0] VEC [7] = '{
    {7'h50, 8'hA0, 1'b1, 1'b0},
    {7'h50, 8'hA1, 1'b1, 1'b1},
    {7'h50, 8'hA2, 1'b0, 1'b0},
    {7'h7F, 8'hFF, 1'b1, 1'b1},
    {7'h00, 8'h00, 1'b1, 1'b0},
    {7'h2A, 8'h55, 1'b1, 1'b1},
    {7'h2A, 8'hD4, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start;
    sda_m = 1'b1; scl = 1'b1; wq(H); sda_m = 1'b0; wq(H); scl = 1'b0; wq(H/2);
  endtask

  task automatic do_restart;
    sda_m = 1'b1; wq(H/2); scl = 1'b1; wq(H); sda_m = 1'b0; wq(H); scl = 1'b0; wq(H/2);
  endtask

  task automatic do_stop;
    sda_m = 1'b0; wq(H/2); scl = 1'b1; wq(H); sda_m = 1'b1; wq(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(H/2); scl = 1'b1; wq(H); scl = 1'b0; wq(H/2);
    end
    sda_m = 1'b1; wq(H/2); scl = 1'b1; wq(H/2);
    a = ~sda_bus;
    wq(H/2); scl = 1'b0; wq(H/2);
  endtask

  initial begin
    #1200000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    wq(5);
    chk("R11 sda_oe", sda_oe, 0);
    chk("R11 selected", selected, 0);
    chk("R11 slave_tx", slave_tx, 0);
    chk("R11 frame_strobe", frame_strobe, 0);
    rst_n = 1'b1; wq(H);

    foreach (VEC[k]) begin
      own_addr = {3'b0, VEC[k][16:10]};
      nstb = 0;
      do_start;
      send_byte(VEC[k][9:2], ack);
      chk($sformatf("R2/R4 vec%0d ack", k), ack, VEC[k][1]);
      chk($sformatf("R2/R4 vec%0d selected", k), selected, VEC[k][1]);
      if (VEC[k][1]) chk($sformatf("R3 vec%0d slave_tx", k), slave_tx, VEC[k][0]);
      chk($sformatf("R9 vec%0d strobes", k), nstb, VEC[k][1]);
      do_stop;
      chk($sformatf("R1 vec%0d stop clears", k), selected, 0);
    end

    own_addr = 10'h050; nstb = 0;
    do_start; send_byte(8'hA0, ack);
    send_byte(8'h3C, ack); send_byte(8'h00, ack);
    chk("R9 three frames", nstb, 3);
    chk("R5 selected in data", selected, 1);
    do_restart;
    chk("R5 kept over restart", selected, 1);
    send_byte(8'hA1, ack);
    chk("R3 read after restart", slave_tx, 1);
    do_restart; send_byte(8'hA4, ack);
    chk("R4 mismatch no ack", ack, 0);
    chk("R4 mismatch deselects", selected, 0);
    do_stop;

    do_start; send_byte(8'hA0, ack);
    sda_m = 1'b0; wq(H/2); scl = 1'b1; wq(H);
    sda_m = 1'b1; wq(2); sda_m = 1'b0; wq(H);
    chk("R10 short pulse ignored", selected, 1);
    sda_m = 1'b1; wq(H);
    chk("R1 stop after glitch", selected, 0);

    ten_bit_mode = 1'b1; own_addr = 10'h2B5;
    do_start; send_byte(8'hF4, ack);
    chk("R6 upper write ack", ack, 1);
    chk("R6 upper alone not selected", selected, 0);
    send_byte(8'hB5, ack);
    chk("R6 low byte ack", ack, 1);
    chk("R6 selected", selected, 1);
    chk("R6 write dir", slave_tx, 0);
    do_restart; send_byte(8'hF5, ack);
    chk("R7 read ack", ack, 1);
    chk("R7 selected", selected, 1);
    chk("R7 slave_tx", slave_tx, 1);
    do_stop;

    do_start; send_byte(8'hF5, ack);
    chk("R8 read after stop no ack", ack, 0);
    chk("R8 read after stop not selected", selected, 0);
    do_stop;

    do_start; send_byte(8'hF4, ack); send_byte(8'hB4, ack);
    chk("R8 wrong low byte no ack", ack, 0);
    do_restart; send_byte(8'hF5, ack);
    chk("R8 read after mismatch no ack", ack, 0);
    do_stop;

    do_start; send_byte(8'hF6, ack);
    chk("R6 wrong upper bits no ack", ack, 0);
    do_stop;

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule